// File: doc/BRIEF.md
# Streaming 3x3 Convolution Prefilter

This block smooths or sharpens a raster stream of 8-bit grayscale pixels by applying a programmable 3x3 kernel. One pixel enters per clock. Each beat carries its X and Y coordinates and a valid flag. Two line memories hold the previous two image rows. A 3x3 register window takes one new column of three pixels for every accepted beat, so it slides one column to the right per pixel and moves on to the next row at the end of a line. The weighted sum of the nine window pixels is scaled, limited to the byte range and sent out as a beat with its own coordinates and valid flag.

Each of the nine kernel weights is a signed fixed-point byte with four integer bits and four fraction bits, so a weight can be anywhere from -8.0 to +7.9375 in steps of 1/16. Negative weights allow edge and sharpening kernels, and their sums can fall below zero. The block is normally placed ahead of a census or feature stage. It holds a blur kernel from reset until a new kernel is loaded.

Top module: `conv3x3_prefilter`

## Requirements
- R1: While `rst` is high and on the first edge after it is released, `out_valid` is low. After reset the active kernel is the default kernel.
- R2: The output pixel is clip(floor(S / 16)), where S = sum over r,c in 0..2 of w[3r+c] * p(x-2+c, y-2+r). Here (x, y) is the beat that completes the window. Weight w[k] is taken from `coef_in[8k+7:8k]`, r=0 is the oldest row and c=0 is the leftmost column.
- R3: A negative scaled sum gives output 0.
- R4: A scaled sum above 255 gives output 255.
- R5: The four fraction bits are dropped by truncation. With a single centre weight of 0x08 (0.5) and all pixels at 101, the output is 50.
- R6: An output is produced only for a completing beat with x >= 2 and y >= 2. It carries `out_x` = x-1 and `out_y` = y-1, the window centre. A frame of H rows and width W therefore yields exactly (H-2)*(W-2) output beats.
- R7: The output beat appears on the fourth rising edge, counting the edge that accepts the completing beat as the first. With continuous input the block accepts one pixel and produces one result per clock.
- R8: A cycle with `in_valid` low is ignored: the window and line memories do not move. Gaps in the input stream do not change the output values.
- R9: The kernel is taken from `coef_in` only on an edge where `coef_load` is high. At other times `coef_in` has no effect on the outputs.
- R10: The default kernel is the blur 1/16*[1 2 1; 2 4 2; 1 2 1]. Its weights are 0x01, 0x02 and 0x04, and a flat frame of value 100 filters to 100.
- R11: When a new frame starts with Y=0, no output is produced for its first two rows. Its later outputs use only pixels from that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_load | input | 1 | Captures `coef_in` as the active kernel |
| coef_in | input | 72 | Nine 4.4 signed weights, weight k at bits [8k+7:8k] |
| in_valid | input | 1 | Input beat valid |
| in_x | input | 10 | Input pixel column |
| in_y | input | 10 | Input pixel row |
| in_pix | input | 8 | Input pixel value |
| out_valid | output | 1 | Output beat valid |
| out_x | output | 10 | Column of the window centre |
| out_y | output | 10 | Row of the window centre |
| out_pix | output | 8 | Filtered, clipped pixel |

## Verification
If a word in a line memory or a window register is wrong, every output whose window covers that pixel comes out wrong, starting four edges after the beat that completes the first such window. A flat frame makes that visible, and a ramp frame shows which column is affected. If the valid and coordinate tags drift from the data, `out_x` and `out_y` no longer match, and the number of outputs per frame differs from (H-2)*(W-2) within the same frame. A weight register that misses a load, or picks up `coef_in` without a load, shows up at once as a change in filtered values across a whole frame. Frames with constant input drive the sum into both clip limits, and these show the clipping behaviour.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int COORD_W = 10;
  localparam int WIN     = 3;
  localparam int TAPS    = WIN * WIN;

  typedef logic [COORD_W-1:0] coord_t;

  typedef struct packed {
    logic   vld;
    coord_t x;
    coord_t y;
  } tag_t;

  // 1/16 * [1 2 1; 2 4 2; 1 2 1] as 4.4 signed bytes, tap 0 in the low byte
  localparam logic [TAPS*8-1:0] BLUR_Q44 = {
    8'h01, 8'h02, 8'h01,
    8'h02, 8'h04, 8'h02,
    8'h01, 8'h02, 8'h01
  };
endpackage

// File: rtl/conv_linebuf.sv
module conv_linebuf import conv_pkg::*; #(
  parameter int IMG_W = 640,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  coord_t           in_x,
  input  coord_t           in_y,
  input  logic [PIX_W-1:0] in_pix,
  output tag_t             s1_tag,
  output logic [PIX_W-1:0] s1_pix,
  output logic [PIX_W-1:0] s1_up1,
  output logic [PIX_W-1:0] s1_up2
);
  localparam int AW = (IMG_W > 1) ? $clog2(IMG_W) : 1;

  // row_a holds the previous row, row_b the row before it
  logic [PIX_W-1:0] row_a [IMG_W];
  logic [PIX_W-1:0] row_b [IMG_W];
  logic [AW-1:0]    wr_addr;
  logic [AW-1:0]    s1_addr;

  assign wr_addr = in_x[AW-1:0];

  // read-before-write single-port style memory for the previous row
  always_ff @(posedge clk) begin
    if (in_valid) begin
      row_a[wr_addr] <= in_pix;
      s1_up1         <= row_a[wr_addr];
      s1_up2         <= row_b[wr_addr];
    end
  end

  // the older row is refilled one cycle later from the word just read
  always_ff @(posedge clk) begin
    if (s1_tag.vld) row_b[s1_addr] <= s1_up1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_tag  <= '0;
      s1_pix  <= '0;
      s1_addr <= '0;
    end else begin
      s1_tag.vld <= in_valid;
      if (in_valid) begin
        s1_tag.x <= in_x;
        s1_tag.y <= in_y;
        s1_pix   <= in_pix;
        s1_addr  <= wr_addr;
      end
    end
  end
endmodule

// File: rtl/conv_window.sv
module conv_window import conv_pkg::*; #(
  parameter int PIX_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  tag_t                  s1_tag,
  input  logic [PIX_W-1:0]      s1_pix,
  input  logic [PIX_W-1:0]      s1_up1,
  input  logic [PIX_W-1:0]      s1_up2,
  output tag_t                  s2_tag,
  output logic [TAPS*PIX_W-1:0] win_flat
);
  logic [PIX_W-1:0] win_q  [WIN][WIN];
  logic [PIX_W-1:0] col_in [WIN];
  logic             full_win;

  assign col_in[0] = s1_up2;
  assign col_in[1] = s1_up1;
  assign col_in[2] = s1_pix;

  // a window is complete only when it spans three columns of the same rows
  assign full_win = (s1_tag.x >= coord_t'(2)) && (s1_tag.y >= coord_t'(2));

  always_ff @(posedge clk) begin
    if (s1_tag.vld) begin
      for (int r = 0; r < WIN; r++) begin
        for (int c = 0; c < WIN-1; c++) win_q[r][c] <= win_q[r][c+1];
        win_q[r][WIN-1] <= col_in[r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_tag <= '0;
    end else begin
      s2_tag.vld <= s1_tag.vld && full_win;
      s2_tag.x   <= s1_tag.x - coord_t'(1);
      s2_tag.y   <= s1_tag.y - coord_t'(1);
    end
  end

  for (genvar r = 0; r < WIN; r++) begin : g_row
    for (genvar c = 0; c < WIN; c++) begin : g_col
      assign win_flat[(r*WIN+c)*PIX_W +: PIX_W] = win_q[r][c];
    end
  end
endmodule

// File: rtl/conv_mac.sv
module conv_mac import conv_pkg::*; #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int FRAC_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  tag_t                   s2_tag,
  input  logic [TAPS*PIX_W-1:0]  win_flat,
  input  logic [TAPS*COEF_W-1:0] kern,
  output tag_t                   o_tag,
  output logic [PIX_W-1:0]       o_pix
);
  localparam int PROD_W = PIX_W + 1 + COEF_W;
  localparam int SUM_W  = PROD_W + $clog2(TAPS);
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((1 << PIX_W) - 1);

  logic signed [PROD_W-1:0] prod_d [TAPS];
  logic signed [PROD_W-1:0] prod_q [TAPS];
  tag_t                     s3_tag;
  logic signed [SUM_W-1:0]  sum;
  logic signed [SUM_W-1:0]  scaled;
  logic [PIX_W-1:0]         clipped;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign prod_d[k] = PROD_W'($signed({1'b0, win_flat[k*PIX_W +: PIX_W]}))
                     * PROD_W'($signed(kern[k*COEF_W +: COEF_W]));
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < TAPS; k++) prod_q[k] <= prod_d[k];
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < TAPS; k++) sum = sum + SUM_W'(prod_q[k]);
    scaled = sum >>> FRAC_W;
    if (scaled < 0)          clipped = '0;
    else if (scaled > MAX_S) clipped = '1;
    else                     clipped = scaled[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s3_tag <= '0;
      o_tag  <= '0;
      o_pix  <= '0;
    end else begin
      s3_tag <= s2_tag;
      o_tag  <= s3_tag;
      o_pix  <= clipped;
    end
  end
endmodule

// File: rtl/conv3x3_prefilter.sv
module conv3x3_prefilter import conv_pkg::*; #(
  parameter int IMG_W  = 640,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int FRAC_W = 4,
  parameter logic [TAPS*COEF_W-1:0] DEFAULT_KERNEL = BLUR_Q44
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   coef_load,
  input  logic [TAPS*COEF_W-1:0] coef_in,
  input  logic                   in_valid,
  input  logic [COORD_W-1:0]     in_x,
  input  logic [COORD_W-1:0]     in_y,
  input  logic [PIX_W-1:0]       in_pix,
  output logic                   out_valid,
  output logic [COORD_W-1:0]     out_x,
  output logic [COORD_W-1:0]     out_y,
  output logic [PIX_W-1:0]       out_pix
);
  logic [TAPS*COEF_W-1:0] kern_q;
  tag_t                   s1_tag;
  tag_t                   s2_tag;
  tag_t                   o_tag;
  logic [PIX_W-1:0]       s1_pix;
  logic [PIX_W-1:0]       s1_up1;
  logic [PIX_W-1:0]       s1_up2;
  logic [TAPS*PIX_W-1:0]  win_flat;

  always_ff @(posedge clk) begin
    if (rst)            kern_q <= DEFAULT_KERNEL;
    else if (coef_load) kern_q <= coef_in;
  end

  conv_linebuf #(.IMG_W(IMG_W), .PIX_W(PIX_W)) u_lines (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_x(in_x), .in_y(in_y), .in_pix(in_pix),
    .s1_tag(s1_tag), .s1_pix(s1_pix), .s1_up1(s1_up1), .s1_up2(s1_up2)
  );

  conv_window #(.PIX_W(PIX_W)) u_win (
    .clk(clk), .rst(rst),
    .s1_tag(s1_tag), .s1_pix(s1_pix), .s1_up1(s1_up1), .s1_up2(s1_up2),
    .s2_tag(s2_tag), .win_flat(win_flat)
  );

  conv_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_mac (
    .clk(clk), .rst(rst),
    .s2_tag(s2_tag), .win_flat(win_flat), .kern(kern_q),
    .o_tag(o_tag), .o_pix(out_pix)
  );

  assign out_valid = o_tag.vld;
  assign out_x     = o_tag.x;
  assign out_y     = o_tag.y;
endmodule

// File: rtl/conv3x3_prefilter_chk.sv
module conv3x3_prefilter_chk import conv_pkg::*; #(
  parameter int IMG_W  = 640,
  parameter int COEF_W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   coef_load,
  input logic [TAPS*COEF_W-1:0] coef_in,
  input logic [TAPS*COEF_W-1:0] kern_q,
  input logic                   in_valid,
  input logic [COORD_W-1:0]     in_x,
  input logic [COORD_W-1:0]     in_y,
  input logic                   out_valid,
  input logic [COORD_W-1:0]     out_x,
  input logic [COORD_W-1:0]     out_y
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R7
  out_source_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 4));

  // R6
  out_x_centre_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_x == coord_t'($past(in_x, 4) - coord_t'(1)));

  // R6
  out_y_centre_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_y == coord_t'($past(in_y, 4) - coord_t'(1)));

  // R6
  out_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_x >= coord_t'(1) && out_x <= coord_t'(IMG_W-2) && out_y >= coord_t'(1)));

  // R9
  kern_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(coef_load) && !$past(rst)) |-> kern_q == $past(coef_in));

  // R9
  kern_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(coef_load) && !$past(rst)) |-> $stable(kern_q));
endmodule

bind conv3x3_prefilter conv3x3_prefilter_chk #(.IMG_W(IMG_W), .COEF_W(COEF_W)) u_chk (
  .clk(clk), .rst(rst), .coef_load(coef_load), .coef_in(coef_in), .kern_q(kern_q),
  .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
  .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
);

// File: tb/sim_conv3x3_prefilter.sv
module sim_conv3x3_prefilter;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 8;
  localparam int MAXH = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        coef_load;
  logic [71:0] coef_in;
  logic        in_valid;
  logic [9:0]  in_x, in_y;
  logic [7:0]  in_pix;
  logic        out_valid;
  logic [9:0]  out_x, out_y;
  logic [7:0]  out_pix;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv3x3_prefilter #(.IMG_W(W)) u0 (
    .clk(clk), .rst(rst), .coef_load(coef_load), .coef_in(coef_in),
    .in_valid(in_valid), .in_x(in_x), .in_y(in_y), .in_pix(in_pix),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_pix(out_pix)
  );

  typedef struct { int x; int y; int d; int due; } exp_t;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  int    got_cnt = 0;
  int    zero_cnt = 0;
  int    last_d = -1;
  string cur_req = "R1";
  exp_t  q[$];
  logic [7:0]        img [MAXH][W];
  logic signed [7:0] kb  [9];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model(input int x, input int y);
    int acc = 0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        acc += int'(kb[r*3+c]) * int'(img[y-2+r][x-2+c]);
    acc = acc >>> 4;
    if (acc < 0) acc = 0;
    if (acc > 255) acc = 255;
    return acc;
  endfunction

  // scoreboard: valid timing (R7), coordinates (R6), data (scenario requirement)
  always @(negedge clk) begin
    if (!rst) begin
      bit due;
      due = (q.size() > 0) && (q[0].due == cyc);
      if (out_valid || due) begin
        chk(out_valid == due, "R7", "out_valid timing", int'(out_valid), int'(due));
        if (out_valid && due) begin
          chk(int'(out_x) == q[0].x, "R6", "out_x", int'(out_x), q[0].x);
          chk(int'(out_y) == q[0].y, "R6", "out_y", int'(out_y), q[0].y);
          chk(int'(out_pix) == q[0].d, cur_req, "out_pix", int'(out_pix), q[0].d);
          got_cnt++;
          last_d = int'(out_pix);
          if (out_pix == 8'd0) zero_cnt++;
        end
        if (due) void'(q.pop_front());
      end
    end
  end

  task automatic drive_px(input int x, input int y, input logic [7:0] p);
    @(negedge clk);
    in_valid = 1'b1;
    in_x = 10'(x);
    in_y = 10'(y);
    in_pix = p;
    img[y][x] = p;
    if (x >= 2 && y >= 2) q.push_back('{x-1, y-1, model(x, y), cyc + 4});
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // mode 0 flat, 1 ramp, 2 random
  task automatic send_frame(input int h, input int mode, input int base,
                            input bit gaps, input bit scramble, input bit post_idle);
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < W; x++) begin
        logic [7:0] p;
        if (mode == 0)      p = 8'(base);
        else if (mode == 1) p = 8'(x*29 + y*17 + base);
        else                p = 8'($urandom_range(255));
        drive_px(x, y, p);
        if (scramble) coef_in = {$urandom, $urandom, 8'($urandom)};
        if (gaps && $urandom_range(2) == 0) idle($urandom_range(3, 1));
      end
    end
    if (post_idle) idle(10);
  endtask

  task automatic load_kernel(input logic [71:0] kv);
    @(negedge clk);
    coef_load = 1'b1;
    coef_in = kv;
    @(negedge clk);
    coef_load = 1'b0;
    coef_in = '0;
    for (int k = 0; k < 9; k++) kb[k] = kv[8*k +: 8];
  endtask

  task automatic t_reset;
    cur_req = "R1";
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (5) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    end
  endtask

  task automatic t_default_blur;
    cur_req = "R10";
    got_cnt = 0;
    send_frame(5, 0, 100, 1'b0, 1'b0, 1'b1);
    chk(last_d == 100, "R10", "flat blur value", last_d, 100);
    chk(got_cnt == 3*(W-2), "R6", "output count", got_cnt, 3*(W-2));
  endtask

  task automatic t_ramp;
    cur_req = "R2";
    got_cnt = 0;
    send_frame(6, 1, 3, 1'b0, 1'b0, 1'b1);
    chk(got_cnt == 4*(W-2), "R6", "output count", got_cnt, 4*(W-2));
  endtask

  task automatic t_coef_ignored;
    cur_req = "R9";
    got_cnt = 0;
    send_frame(5, 2, 0, 1'b0, 1'b1, 1'b0);
    coef_in = '0;
    idle(10);
    chk(got_cnt == 3*(W-2), "R9", "output count", got_cnt, 3*(W-2));
  endtask

  task automatic t_edge_kernel;
    cur_req = "R3";
    load_kernel({8'hF0, 8'hF0, 8'hF0, 8'hF0, 8'h7F, 8'hF0, 8'hF0, 8'hF0, 8'hF0});
    zero_cnt = 0;
    got_cnt = 0;
    send_frame(8, 2, 0, 1'b0, 1'b0, 1'b1);
    chk(zero_cnt > 0, "R3", "clipped zero outputs seen", zero_cnt, 1);
    chk(got_cnt == 6*(W-2), "R6", "output count", got_cnt, 6*(W-2));
  endtask

  task automatic t_saturate;
    cur_req = "R4";
    load_kernel({9{8'h7F}});
    send_frame(3, 0, 255, 1'b0, 1'b0, 1'b1);
    chk(last_d == 255, "R4", "high clip", last_d, 255);
    cur_req = "R3";
    load_kernel({9{8'h80}});
    send_frame(3, 0, 200, 1'b0, 1'b0, 1'b1);
    chk(last_d == 0, "R3", "low clip", last_d, 0);
  endtask

  task automatic t_truncate;
    cur_req = "R5";
    load_kernel({8'h00, 8'h00, 8'h00, 8'h00, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00});
    send_frame(3, 0, 101, 1'b0, 1'b0, 1'b1);
    chk(last_d == 50, "R5", "truncated half", last_d, 50);
  endtask

  task automatic t_gaps;
    cur_req = "R8";
    load_kernel({8'h01, 8'h02, 8'h01, 8'h02, 8'h04, 8'h02, 8'h01, 8'h02, 8'h01});
    got_cnt = 0;
    send_frame(6, 2, 0, 1'b1, 1'b0, 1'b1);
    chk(got_cnt == 4*(W-2), "R8", "output count with gaps", got_cnt, 4*(W-2));
  endtask

  task automatic t_back_to_back;
    cur_req = "R11";
    load_kernel({8'hF8, 8'h10, 8'h00, 8'h10, 8'h30, 8'h10, 8'h00, 8'h10, 8'hF8});
    got_cnt = 0;
    send_frame(5, 2, 0, 1'b0, 1'b0, 1'b0);
    send_frame(5, 1, 40, 1'b0, 1'b0, 1'b1);
    chk(got_cnt == 2*3*(W-2), "R11", "output count over two frames", got_cnt, 2*3*(W-2));
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    rst = 1'b1;
    coef_load = 1'b0;
    coef_in = '0;
    in_valid = 1'b0;
    in_x = '0;
    in_y = '0;
    in_pix = '0;
    kb = '{8'sd1, 8'sd2, 8'sd1, 8'sd2, 8'sd4, 8'sd2, 8'sd1, 8'sd2, 8'sd1};
    repeat (3) @(negedge clk);
    t_reset();
    t_default_blur();
    t_ramp();
    t_coef_ignored();
    t_edge_kernel();
    t_saturate();
    t_truncate();
    t_gaps();
    t_back_to_back();
    idle(10);
    chk(q.size() == 0, "R7", "pending expected outputs", q.size(), 0);
    finish_run();
  end
endmodule